// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a set of on-chip configuration registers from a serial EEPROM that is wired to three signals plus chip select (Microwire style). It reads a fixed image of `NBYTES` bytes as 16-bit words. Each word is fetched with its own READ frame, and the words are addressed upward from word 0.

A load begins by itself as soon as synchronous reset is released. The host can start another load later with a one-cycle request. The valid flag drops at the start of every load. It rises again only if the EEPROM answered every frame and the 8-bit sum of all bytes is 0xFF. The image is first collected in a staging buffer and is copied into the configuration registers only after the sum has passed, so the registers never hold part of an image. When a load fails, either because no device answered or because the sum was wrong, every configuration register goes back to its reset default.

While a load runs, the block signals busy and does not acknowledge host reads. The serial clock runs as a divided clock enable of the system clock.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While `rst` is high and after it is released, `busy`=1, `load_cmd`=1, `cfg_valid`=0 and `ee_sel`=0. Once reset is released, `ee_sel` rises with no host action, starting the automatic load.
- R2: Each frame keeps `ee_sel` high. On rising `ee_clk` edges 1 to 3, `ee_dout` carries 1, 1, 0. On edges 4 to `ROM_AW`+3 it carries the word address, MSB first. Addresses run 0, 1, 2 and so on. On edge `ROM_AW`+4 the block samples the dummy bit from `ee_din`. On the next 16 edges it samples the data word, MSB first. The first byte of a word is its upper half.
- R3: Between two frames, `ee_sel` stays low for at least 2*`CLK_DIV` clock cycles, which is one `ee_clk` period.
- R4: A `load_req` accepted while idle sets `cfg_valid`=0, `busy`=1 and `load_cmd`=1 at the next clock edge, while `ee_sel` is still low.
- R5: A load that finds a device issues exactly `NBYTES`/2 frames.
- R6: If the dummy bit reads 1, the load ends after that frame, with no further frame. `load_cmd` and `busy` return to 0 and `cfg_valid` stays 0. This applies to both the automatic load and a host-requested load.
- R7: When the 8-bit sum of all bytes equals 0xFF, the load ends with `cfg_valid`=1, and word i of the configuration registers equals EEPROM word i.
- R8: A failed load (device absent or sum wrong) ends with `cfg_valid`=0 and every word back at its default. The default of word i is 0x5A00 + i*0x0101, taken modulo 2^16.
- R9: While `busy`=1, `rd_en` receives no `rd_ack`. When `busy`=0, `rd_en` gives `rd_ack`=1 one cycle later, with `rd_data` equal to word `rd_addr`.
- R10: A `load_req` that arrives while a load is running has no effect: the running load continues with its frame count and address sequence unchanged.
- R11: `load_cmd` falls to 0 in the same cycle that `busy` falls, when the load ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hard reset |
| load_req | input | 1 | One-cycle host request to reload the image |
| rd_en | input | 1 | Host read strobe for a configuration word |
| rd_addr | input | $clog2(NBYTES/2) | Configuration word index |
| rd_ack | output | 1 | Read answered; rd_data valid |
| rd_data | output | 16 | Configuration word read back |
| busy | output | 1 | Load in progress; host accesses stalled |
| load_cmd | output | 1 | Read-command status, self-clearing at end of load |
| cfg_valid | output | 1 | Image present and checksum correct |
| ee_sel | output | 1 | EEPROM chip select |
| ee_clk | output | 1 | EEPROM serial clock |
| ee_dout | output | 1 | Serial data toward the EEPROM |
| ee_din | input | 1 | Serial data from the EEPROM (idles high) |

## Verification
The two events that can fall in the same cycle are the host read path and the end of a load, when `busy` drops and the new image has just been committed. To provoke this, `rd_en` is held high through an entire host-requested reload. The reload itself is started by a request that is checked to clear `cfg_valid` before chip select moves. The run passes if no acknowledge appears while `busy` was high, and if the first acknowledge comes one cycle after `busy` falls carrying the word from the new image. A second request is sent during the same load, and the frame count and address order are checked to confirm it changed nothing.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

  typedef enum logic [2:0] {
    LD_IDLE, LD_START, LD_WAIT, LD_CHECK, LD_COMMIT, LD_FINISH, LD_FAIL
  } ld_state_t;

  typedef enum logic [1:0] {
    MW_IDLE, MW_SHIFT, MW_GAP
  } mw_state_t;

  // reset value of configuration word idx
  function automatic logic [15:0] dflt_word(input logic [15:0] seed, input int unsigned idx);
    logic [7:0] b;
    b = 8'(idx);
    return seed + {b, b};
  endfunction

endpackage

// File: rtl/eecfg_tick_gen.sv
module eecfg_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/eecfg_mw_reader.sv
module eecfg_mw_reader
  import eecfg_pkg::*;
#(
  parameter int AW  = 6,
  parameter int WW  = 16,
  parameter int DIV = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          go,
  input  logic [AW-1:0] addr,
  input  logic          ee_din,
  output logic          done,
  output logic          absent,
  output logic [WW-1:0] word,
  output logic          ee_sel,
  output logic          ee_clk,
  output logic          ee_dout
);
  localparam int NBITS    = 3 + AW + 1 + WW;
  localparam int DUMMY_IX = 3 + AW;
  localparam int LAST_IX  = NBITS - 1;
  localparam int BW       = $clog2(NBITS);

  mw_state_t     st;
  logic [BW-1:0] bitn;
  logic          half;
  logic          gap;
  logic [AW-1:0] addr_q;
  logic [WW-1:0] shreg;

  // bit b of the outgoing command: start, opcode, address
  function automatic logic cmd_bit(input int b, input logic [AW-1:0] a);
    if (b < 2) return 1'b1;
    if (b == 2) return 1'b0;
    if (b < 3 + AW) return a[AW + 2 - b];
    return 1'b0;
  endfunction

  assign word = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= MW_IDLE;
      ee_sel  <= 1'b0;
      ee_clk  <= 1'b0;
      ee_dout <= 1'b0;
      done    <= 1'b0;
      absent  <= 1'b0;
      bitn    <= '0;
      half    <= 1'b0;
      gap     <= 1'b0;
      addr_q  <= '0;
      shreg   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        MW_IDLE: if (go) begin
          addr_q  <= addr;
          ee_sel  <= 1'b1;
          ee_clk  <= 1'b0;
          ee_dout <= 1'b1;
          bitn    <= '0;
          half    <= 1'b0;
          absent  <= 1'b0;
          st      <= MW_SHIFT;
        end
        MW_SHIFT: if (tick) begin
          if (!half) begin
            ee_clk <= 1'b1;
            half   <= 1'b1;
            if (bitn == BW'(DUMMY_IX) && ee_din) absent <= 1'b1;
            if (bitn > BW'(DUMMY_IX)) shreg <= {shreg[WW-2:0], ee_din};
          end else begin
            ee_clk <= 1'b0;
            half   <= 1'b0;
            if (bitn == BW'(LAST_IX) || absent) begin
              ee_sel  <= 1'b0;
              ee_dout <= 1'b0;
              gap     <= 1'b0;
              st      <= MW_GAP;
            end else begin
              bitn    <= bitn + 1'b1;
              ee_dout <= cmd_bit(int'(bitn) + 1, addr_q);
            end
          end
        end
        MW_GAP: if (tick) begin
          if (gap) begin
            done <= 1'b1;
            st   <= MW_IDLE;
          end else begin
            gap <= 1'b1;
          end
        end
        default: st <= MW_IDLE;
      endcase
    end
  end

  // chip-select low time since the previous frame, for the gap check
  logic [15:0] lo_cnt;
  logic        had_frame;
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt    <= '0;
      had_frame <= 1'b0;
    end else begin
      if (ee_sel) begin
        lo_cnt    <= '0;
        had_frame <= 1'b1;
      end else if (!(&lo_cnt)) begin
        lo_cnt <= lo_cnt + 1'b1;
      end
    end
  end

  // R3: chip select low for one serial period between frames
  a_r3_sel_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(ee_sel) && had_frame) |-> (lo_cnt >= 16'(2 * DIV)));

  // R2: each frame opens with the serial clock low
  a_r2_sel_clk_low: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_sel) |-> !ee_clk);

  // R6: an absent device closes the frame before reporting
  a_r6_absent_closed: assert property (@(posedge clk) disable iff (rst)
    (done && absent) |-> !ee_sel);
endmodule

// File: rtl/eecfg_stage_ram.sv
module eecfg_stage_ram #(
  parameter int DEPTH = 18,
  parameter int WW    = 16,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int          NBYTES   = 36,
  parameter int          CLK_DIV  = 2,
  parameter int          ROM_AW   = 6,
  parameter logic [15:0] DEF_SEED = 16'h5A00
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load_req,
  input  logic                          rd_en,
  input  logic [$clog2(NBYTES/2)-1:0]   rd_addr,
  output logic                          rd_ack,
  output logic [15:0]                   rd_data,
  output logic                          busy,
  output logic                          load_cmd,
  output logic                          cfg_valid,
  output logic                          ee_sel,
  output logic                          ee_clk,
  output logic                          ee_dout,
  input  logic                          ee_din
);
  localparam int NWORDS = NBYTES / 2;
  localparam int IX_W   = $clog2(NWORDS);
  localparam logic [7:0] SUM_OK = 8'hFF;

  ld_state_t       st;
  logic [IX_W-1:0] idx, cidx, wr_ix;
  logic            wr_pend;
  logic [7:0]      sum;
  logic [15:0]     shadow [NWORDS];

  logic            tick, go, fr_done, fr_absent;
  logic [15:0]     fr_word, ram_rdata;

  assign go = (st == LD_START);

  eecfg_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk (clk), .rst (rst), .tick (tick)
  );

  eecfg_mw_reader #(.AW(ROM_AW), .WW(16), .DIV(CLK_DIV)) u_mw (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .go      (go),
    .addr    (ROM_AW'(idx)),
    .ee_din  (ee_din),
    .done    (fr_done),
    .absent  (fr_absent),
    .word    (fr_word),
    .ee_sel  (ee_sel),
    .ee_clk  (ee_clk),
    .ee_dout (ee_dout)
  );

  eecfg_stage_ram #(.DEPTH(NWORDS), .WW(16), .AW(IX_W)) u_stage (
    .clk   (clk),
    .we    (st == LD_WAIT && fr_done && !fr_absent),
    .waddr (idx),
    .wdata (fr_word),
    .raddr (cidx),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= LD_START;
      idx       <= '0;
      cidx      <= '0;
      wr_ix     <= '0;
      wr_pend   <= 1'b0;
      sum       <= '0;
      busy      <= 1'b1;
      load_cmd  <= 1'b1;
      cfg_valid <= 1'b0;
      for (int i = 0; i < NWORDS; i++) shadow[i] <= dflt_word(DEF_SEED, i);
    end else begin
      wr_pend <= 1'b0;
      if (wr_pend) shadow[wr_ix] <= ram_rdata;
      case (st)
        LD_IDLE: if (load_req) begin
          cfg_valid <= 1'b0;
          busy      <= 1'b1;
          load_cmd  <= 1'b1;
          idx       <= '0;
          sum       <= '0;
          st        <= LD_START;
        end
        LD_START: st <= LD_WAIT;
        LD_WAIT: if (fr_done) begin
          if (fr_absent) begin
            st <= LD_FAIL;
          end else begin
            sum <= sum + fr_word[15:8] + fr_word[7:0];
            if (idx == IX_W'(NWORDS - 1)) begin
              cidx <= '0;
              st   <= LD_CHECK;
            end else begin
              idx <= idx + 1'b1;
              st  <= LD_START;
            end
          end
        end
        LD_CHECK: st <= (sum == SUM_OK) ? LD_COMMIT : LD_FAIL;
        LD_COMMIT: begin
          wr_pend <= 1'b1;
          wr_ix   <= cidx;
          if (cidx == IX_W'(NWORDS - 1)) st <= LD_FINISH;
          else cidx <= cidx + 1'b1;
        end
        LD_FINISH: begin
          cfg_valid <= 1'b1;
          busy      <= 1'b0;
          load_cmd  <= 1'b0;
          st        <= LD_IDLE;
        end
        LD_FAIL: begin
          for (int i = 0; i < NWORDS; i++) shadow[i] <= dflt_word(DEF_SEED, i);
          cfg_valid <= 1'b0;
          busy      <= 1'b0;
          load_cmd  <= 1'b0;
          st        <= LD_IDLE;
        end
        default: st <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= rd_en && !busy;
      if (rd_en && !busy)
        rd_data <= (int'(rd_addr) < NWORDS) ? shadow[rd_addr] : 16'h0000;
    end
  end

  // R4: accepted request clears the flag before any frame starts
  a_r4_req_clears: assert property (@(posedge clk) disable iff (rst)
    (st == LD_IDLE && load_req) |=> (!cfg_valid && busy && !ee_sel));

  // R7: the valid flag is never shown during a load
  a_r7_valid_idle: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> !busy);

  // R11: command bit is clear once busy drops
  a_r11_cmd_drops: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !load_cmd);

  // R10: a request during a load keeps the load running
  a_r10_busy_holds: assert property (@(posedge clk) disable iff (rst)
    (busy && load_req && st == LD_WAIT && !fr_done) |=> busy);

  // R5: the word index stays inside the image while frames run
  a_r5_idx_range: assert property (@(posedge clk) disable iff (rst)
    (st == LD_WAIT) |-> (int'(idx) < NWORDS));
endmodule

// File: tb/eeprom_cfg_loader_bench.sv
module eeprom_cfg_loader_bench;
  localparam int NBYTES = 36;
  localparam int NW     = NBYTES / 2;
  localparam int DIV    = 2;
  localparam int AW     = 6;
  localparam int IXW    = $clog2(NW);
  localparam logic [15:0] SEED = 16'h5A00;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           load_req = 1'b0;
  logic           rd_en = 1'b0;
  logic [IXW-1:0] rd_addr = '0;
  logic           rd_ack;
  logic [15:0]    rd_data;
  logic           busy, load_cmd, cfg_valid;
  logic           ee_sel, ee_clk, ee_dout;
  logic           ee_din = 1'b1;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  eeprom_cfg_loader #(.NBYTES(NBYTES), .CLK_DIV(DIV), .ROM_AW(AW), .DEF_SEED(SEED)) u_eeprom_cfg_loader (
    .clk (clk), .rst (rst), .load_req (load_req),
    .rd_en (rd_en), .rd_addr (rd_addr), .rd_ack (rd_ack), .rd_data (rd_data),
    .busy (busy), .load_cmd (load_cmd), .cfg_valid (cfg_valid),
    .ee_sel (ee_sel), .ee_clk (ee_clk), .ee_dout (ee_dout), .ee_din (ee_din)
  );

  // ---------------- EEPROM model ----------------
  logic [15:0]   img [NW];
  bit            present = 1'b1;
  int            epoch = 0;
  int            ep_seen = -1;
  int            fidx = 0;
  int            proto_err = 0;
  int            gap_err = 0;
  int            clk_n = 0;
  int            sel_fall_at = 0;
  int            sk_cnt = 0;
  bit            in_frame = 1'b0;
  bit            seen_frame = 1'b0;
  logic [AW-1:0] fr_addr = '0;

  always @(posedge clk) clk_n++;

  always @(posedge ee_clk or posedge ee_sel or negedge ee_sel) begin
    if (!ee_sel) begin
      if (in_frame) sel_fall_at = clk_n;
      in_frame = 1'b0;
      sk_cnt   = 0;
      ee_din  <= 1'b1;
    end else if (!in_frame) begin
      in_frame = 1'b1;
      if (ep_seen != epoch) begin
        ep_seen    = epoch;
        fidx       = 0;
        seen_frame = 1'b0;
      end
      if (seen_frame && (clk_n - sel_fall_at) < 2 * DIV) gap_err++;
      seen_frame = 1'b1;
      fidx++;
      fr_addr = '0;
    end else if (ee_clk) begin
      sk_cnt++;
      if (sk_cnt <= 3) begin
        if (ee_dout !== (sk_cnt != 3)) proto_err++;
      end else if (sk_cnt <= 3 + AW) begin
        fr_addr = {fr_addr[AW-2:0], ee_dout};
        if (sk_cnt == 3 + AW) begin
          if (int'(fr_addr) != fidx - 1) proto_err++;
          ee_din <= present ? 1'b0 : 1'b1;
        end
      end else if (sk_cnt <= 3 + AW + 16 && int'(fr_addr) < NW) begin
        ee_din <= img[fr_addr][3 + AW + 16 - sk_cnt];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(input int i);
    return SEED + 16'(i) * 16'h0101;
  endfunction

  task automatic make_image(input int base, input bit good);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < NW; i++) begin
      img[i] = 16'(base + i * 16'h1357);
      if (i < NW - 1) s = s + img[i][15:8] + img[i][7:0];
      else s = s + img[i][15:8];
    end
    img[NW-1][7:0] = 8'hFF - s;
    if (!good) img[NW-1][7:0] = img[NW-1][7:0] ^ 8'h01;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic read_word(input int i, output logic ack, output logic [15:0] d);
    rd_en   = 1'b1;
    rd_addr = IXW'(i);
    @(negedge clk);
    rd_en = 1'b0;
    ack = rd_ack;
    d   = rd_data;
  endtask

  task automatic host_load();
    epoch++;
    load_req = 1'b1;
    @(negedge clk);
    load_req = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_auto();
    bit seen;
    make_image(16'h1200, 1'b1);
    present = 1'b1;
    rst = 1'b1;
    epoch++;
    repeat (3) @(negedge clk);
    check(busy == 1'b1 && load_cmd == 1'b1, "R1 reset busy/cmd", {busy, load_cmd}, 2'b11);
    check(cfg_valid == 1'b0 && ee_sel == 1'b0, "R1 reset valid/sel", {cfg_valid, ee_sel}, 2'b00);
    rst = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      seen = ee_sel;
    end
    check(seen, "R1 auto load start", seen, 1);
    wait_idle();
    check(cfg_valid == 1'b1, "R7 valid after good auto load", cfg_valid, 1);
    check(load_cmd == 1'b0, "R11 cmd bit cleared", load_cmd, 0);
    check(fidx == NW, "R5 frame count", fidx, NW);
    check(proto_err == 0, "R2 frame format", proto_err, 0);
    check(gap_err == 0, "R3 select gap", gap_err, 0);
  endtask

  task automatic t_readback();
    logic ack;
    logic [15:0] d;
    for (int i = 0; i < NW; i++) begin
      read_word(i, ack, d);
      check(ack == 1'b1 && d == img[i], "R7 R9 word readback", {ack, d}, {1'b1, img[i]});
    end
  endtask

  task automatic t_host_reload_collision();
    int  bad;
    bit  prev, got;
    make_image(16'h7700, 1'b1);
    host_load();
    check(cfg_valid == 1'b0 && busy == 1'b1 && load_cmd == 1'b1 && ee_sel == 1'b0,
          "R4 request clears valid first", {cfg_valid, busy, load_cmd, ee_sel}, 4'b0110);
    rd_en   = 1'b1;
    rd_addr = IXW'(5);
    repeat (300) @(negedge clk);
    load_req = 1'b1;          // R10: request while busy
    @(negedge clk);
    load_req = 1'b0;
    bad  = 0;
    got  = 1'b0;
    prev = busy;
    for (int i = 0; i < 20000 && !got; i++) begin
      @(negedge clk);
      if (prev && rd_ack) bad++;
      if (!prev) begin
        got = 1'b1;
        check(rd_ack == 1'b1 && rd_data == img[5], "R9 first ack after load end",
              {rd_ack, rd_data}, {1'b1, img[5]});
      end
      prev = busy;
    end
    rd_en = 1'b0;
    check(bad == 0, "R9 no ack while busy", bad, 0);
    check(cfg_valid == 1'b1, "R7 valid after host reload", cfg_valid, 1);
    check(fidx == NW && proto_err == 0, "R10 busy request ignored", fidx, NW);
    check(load_cmd == 1'b0, "R11 cmd bit cleared", load_cmd, 0);
  endtask

  task automatic t_bad_sum();
    logic ack;
    logic [15:0] d;
    make_image(16'h3300, 1'b0);
    host_load();
    wait_idle();
    check(cfg_valid == 1'b0, "R8 valid low on bad sum", cfg_valid, 0);
    check(fidx == NW, "R5 frame count bad sum", fidx, NW);
    read_word(0, ack, d);
    check(ack && d == dflt(0), "R8 word 0 reverted", d, dflt(0));
    read_word(NW - 1, ack, d);
    check(ack && d == dflt(NW - 1), "R8 last word reverted", d, dflt(NW - 1));
  endtask

  task automatic t_absent();
    logic ack;
    logic [15:0] d;
    make_image(16'h4400, 1'b1);
    present = 1'b1;
    host_load();
    wait_idle();
    check(cfg_valid == 1'b1, "R7 valid before absent test", cfg_valid, 1);
    present = 1'b0;
    host_load();
    wait_idle();
    repeat (10) @(negedge clk);
    check(fidx == 1, "R6 host load stops after one frame", fidx, 1);
    check(cfg_valid == 1'b0 && load_cmd == 1'b0 && busy == 1'b0, "R6 absent end state",
          {cfg_valid, load_cmd, busy}, 3'b000);
    read_word(3, ack, d);
    check(ack && d == dflt(3), "R8 revert after absent", d, dflt(3));
    rst = 1'b1;
    epoch++;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    wait_idle();
    repeat (10) @(negedge clk);
    check(fidx == 1 && cfg_valid == 1'b0 && load_cmd == 1'b0, "R6 auto load absent",
          {fidx[7:0], cfg_valid, load_cmd}, {8'd1, 2'b00});
    present = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset_auto();
    t_readback();
    t_host_reload_collision();
    t_bad_sum();
    t_absent();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule